// File: doc/BRIEF.md
# Registered 12/24-bit bus exchanger

This block connects a narrow side (the A port, 12 bits) to a wide side made of two 12-bit halves, 1B and 2B. Toward the wide side, each half has its own capture register with an active-low load strobe. Strobing the low half on one clock and the high half on the next clock gathers two successive A words into one 24-bit word, `{b2_out, b1_out}`. Toward the narrow side, a single return register reloads on every clock from one of the two halves, chosen by a select input.

Each port's tristate driver is modelled as a data output plus a drive flag. The three active-low output-enable inputs pass through flops, so a drive flag only changes at the clock edge after its enable input changes. A keeper on each port gives a line-level output. It follows the driven data while the port drives. After the port stops driving, it holds the last value the port put on the line.

A synchronous active-low reset clears every data and keeper register to zero and turns all three drivers off. Without reset, the drive state is unknown until the first clock edge.

Top module: `reg_bus_exchanger`

## Requirements
- R1: A clock edge with `rst_n` low sets `a_out`, `b1_out`, `b2_out`, `a_lvl`, `b1_lvl` and `b2_lvl` to zero and clears all three drive flags to 0.
- R2: At a clock edge with `ld1_n` low, `b1_out` takes the value of `a_in`. At a clock edge with `ld1_n` high, `b1_out` keeps its value.
- R3: At a clock edge with `ld2_n` low, `b2_out` takes the value of `a_in`. At a clock edge with `ld2_n` high, `b2_out` keeps its value.
- R4: Strobing `ld1_n` low on one edge and then `ld2_n` low on the next edge presents the first word in bits 11:0 and the second word in bits 23:12 of `{b2_out, b1_out}`. Strobing both low on one edge writes the same word into both halves.
- R5: At every clock edge, `a_out` loads `b1_in` when `pick_1b` is 1 and loads `b2_in` when `pick_1b` is 0.
- R6: Each drive flag (`a_drive`, `b1_drive`, `b2_drive`) equals the inverse of its enable input (`a_oe_n`, `b1_oe_n`, `b2_oe_n`) as sampled at the previous edge. A change of an enable input does not reach the flag before the next edge.
- R7: The data registers load as R2, R3 and R5 describe whether or not their port is driving.
- R8: While a port drives, its `*_lvl` output equals its data output. While it does not drive, `*_lvl` holds the last level the port drove, and later loads of the data register do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register loads on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 12 | Data arriving on the narrow port |
| b1_in | input | 12 | Data arriving on the low wide half |
| b2_in | input | 12 | Data arriving on the high wide half |
| ld1_n | input | 1 | Load strobe for the low-half register, active low |
| ld2_n | input | 1 | Load strobe for the high-half register, active low |
| pick_1b | input | 1 | Return-path select: 1 picks the low half, 0 picks the high half |
| a_oe_n | input | 1 | Narrow-port output enable, active low, registered |
| b1_oe_n | input | 1 | Low-half output enable, active low, registered |
| b2_oe_n | input | 1 | High-half output enable, active low, registered |
| a_out | output | 12 | Return register contents, driven onto the narrow port |
| a_drive | output | 1 | Narrow-port driver on |
| b1_out | output | 12 | Low-half capture register contents |
| b1_drive | output | 1 | Low-half driver on |
| b2_out | output | 12 | High-half capture register contents |
| b2_drive | output | 1 | High-half driver on |
| a_lvl | output | 12 | Narrow-port line level, including the keeper |
| b1_lvl | output | 12 | Low-half line level, including the keeper |
| b2_lvl | output | 12 | High-half line level, including the keeper |

## Verification
The bench checks that an enable input changed ahead of an edge leaves the drive flag untouched until that edge. A design that let the enable through combinationally would switch the flag early. A lane whose strobe is held high is checked to keep its word while the other lane captures. A design that shared one load term would overwrite both halves and corrupt the 24-bit pair. When the narrow driver turns off, the return register keeps reloading, and the line level is checked against the last driven value. A keeper that followed the register would show the new data instead. Reset is applied in the middle of a run with strobes and enables active, which catches drive flags or keepers left out of the reset.

// File: rtl/bx_pkg.sv
// Shared definitions for the bus exchanger.
// Assumes three tristate ports, numbered in the order narrow, low half, high half.
package bx_pkg;
    localparam int NPORT = 3;
    localparam int NLANE = 2;

    typedef enum logic [1:0] {
        PORT_A  = 2'd0,
        PORT_B1 = 2'd1,
        PORT_B2 = 2'd2
    } port_idx_e;
endpackage

// File: rtl/bx_load_reg.sv
// One wide-side capture register with an active-low load strobe.
// Assumes a synchronous active-low reset; the strobe takes effect at the same edge.
module bx_load_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Capture d when the strobe is low, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ld_n)
            q <= d;
    end
endmodule

// File: rtl/bx_return_reg.sv
// Narrow-side return register: reloads every edge from the selected wide half.
// Assumes pick=1 selects the low half; there is no hold term.
module bx_return_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick,
    input  logic [WORD_W-1:0] lo_half,
    input  logic [WORD_W-1:0] hi_half,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] next_w;

    // Choose the source half.
    always_comb next_w = pick ? lo_half : hi_half;

    // Load on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= next_w;
    end
endmodule

// File: rtl/bx_oe_reg.sv
// Registers the active-low output enables and presents active-high drive flags.
// Assumes reset must leave every driver off; without reset the state is unknown until an edge.
module bx_oe_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] oe_n,
    output logic [N-1:0] drive
);
    logic [N-1:0] oe_q;

    // Sample the enables; reset forces the disabled level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_q <= '1;
        else
            oe_q <= oe_n;
    end

    // Flip the polarity for the drive flags.
    always_comb drive = ~oe_q;
endmodule

// File: rtl/bx_keeper.sv
// Bus-hold model for one port: the line shows the driven data while driving,
// and otherwise the level that was last on the line.
// Assumes no other driver on the line is modelled.
module bx_keeper #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] lvl
);
    logic [WORD_W-1:0] keep_q;

    // Line level: the driven data, or the kept value.
    always_comb lvl = drive ? data : keep_q;

    // Remember the level on the line at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_q <= '0;
        else
            keep_q <= lvl;
    end
endmodule

// File: rtl/reg_bus_exchanger.sv
// Registered 12/24-bit bus exchanger top level.
// Two wide-side capture lanes, one narrow-side return register, registered
// output enables and one keeper per port. Assumes a single clock domain.
module reg_bus_exchanger #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    input  logic              ld1_n,
    input  logic              ld2_n,
    input  logic              pick_1b,
    input  logic              a_oe_n,
    input  logic              b1_oe_n,
    input  logic              b2_oe_n,
    output logic [WORD_W-1:0] a_out,
    output logic              a_drive,
    output logic [WORD_W-1:0] b1_out,
    output logic              b1_drive,
    output logic [WORD_W-1:0] b2_out,
    output logic              b2_drive,
    output logic [WORD_W-1:0] a_lvl,
    output logic [WORD_W-1:0] b1_lvl,
    output logic [WORD_W-1:0] b2_lvl
);
    import bx_pkg::*;

    logic [NLANE-1:0]  lane_ld_n;
    logic [WORD_W-1:0] lane_q  [NLANE];
    logic [NPORT-1:0]  oe_n_vec;
    logic [NPORT-1:0]  drv_vec;
    logic [WORD_W-1:0] port_dat [NPORT];
    logic [WORD_W-1:0] port_lvl [NPORT];
    logic [WORD_W-1:0] ret_q;

    // Gather the lane strobes and the port enables.
    always_comb begin
        lane_ld_n         = {ld2_n, ld1_n};
        oe_n_vec[PORT_A]  = a_oe_n;
        oe_n_vec[PORT_B1] = b1_oe_n;
        oe_n_vec[PORT_B2] = b2_oe_n;
    end

    // Wide-side capture lanes, both fed from the narrow port.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        bx_load_reg #(.WORD_W(WORD_W)) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_n  (lane_ld_n[g]),
            .d     (a_in),
            .q     (lane_q[g])
        );
    end

    bx_return_reg #(.WORD_W(WORD_W)) ret_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick    (pick_1b),
        .lo_half (b1_in),
        .hi_half (b2_in),
        .q       (ret_q)
    );

    bx_oe_reg #(.N(NPORT)) oe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .oe_n  (oe_n_vec),
        .drive (drv_vec)
    );

    // Route each port's data register to its keeper.
    always_comb begin
        port_dat[PORT_A]  = ret_q;
        port_dat[PORT_B1] = lane_q[0];
        port_dat[PORT_B2] = lane_q[1];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_keep
        bx_keeper #(.WORD_W(WORD_W)) keep_i (
            .clk   (clk),
            .rst_n (rst_n),
            .drive (drv_vec[p]),
            .data  (port_dat[p]),
            .lvl   (port_lvl[p])
        );
    end

    // Drive the output ports.
    always_comb begin
        a_out    = ret_q;
        b1_out   = lane_q[0];
        b2_out   = lane_q[1];
        a_drive  = drv_vec[PORT_A];
        b1_drive = drv_vec[PORT_B1];
        b2_drive = drv_vec[PORT_B2];
        a_lvl    = port_lvl[PORT_A];
        b1_lvl   = port_lvl[PORT_B1];
        b2_lvl   = port_lvl[PORT_B2];
    end
endmodule

// File: rtl/reg_bus_exchanger_chk.sv
// Property checker for the bus exchanger, attached by bind.
// Observes the top-level ports only.
module reg_bus_exchanger_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b1_in,
    input logic [WORD_W-1:0] b2_in,
    input logic              ld1_n,
    input logic              ld2_n,
    input logic              pick_1b,
    input logic              a_oe_n,
    input logic              b1_oe_n,
    input logic              b2_oe_n,
    input logic [WORD_W-1:0] a_out,
    input logic              a_drive,
    input logic [WORD_W-1:0] b1_out,
    input logic              b1_drive,
    input logic [WORD_W-1:0] b2_out,
    input logic              b2_drive,
    input logic [WORD_W-1:0] a_lvl,
    input logic [WORD_W-1:0] b1_lvl,
    input logic [WORD_W-1:0] b2_lvl
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!a_drive && !b1_drive && !b2_drive && a_out == '0
                           && b1_out == '0 && b2_out == '0 && a_lvl == '0));

    // R2
    b1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld1_n)) |-> b1_out == $past(a_in));

    // R2
    b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld1_n)) |-> $stable(b1_out));

    // R3
    b2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld2_n)) |-> b2_out == $past(a_in));

    // R3
    b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld2_n)) |-> $stable(b2_out));

    // R5
    ret_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> a_out == ($past(pick_1b) ? $past(b1_in) : $past(b2_in)));

    // R6
    oe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_drive == !$past(a_oe_n) && b1_drive == !$past(b1_oe_n)
                          && b2_drive == !$past(b2_oe_n)));

    // R8
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive |-> a_lvl == a_out);

    // R8
    lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !a_drive) |-> a_lvl == $past(a_lvl));

    // R8
    b2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !b2_drive) |-> b2_lvl == $past(b2_lvl));
endmodule

bind reg_bus_exchanger reg_bus_exchanger_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .ld1_n(ld1_n), .ld2_n(ld2_n), .pick_1b(pick_1b), .a_oe_n(a_oe_n),
    .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n), .a_out(a_out), .a_drive(a_drive),
    .b1_out(b1_out), .b1_drive(b1_drive), .b2_out(b2_out), .b2_drive(b2_drive),
    .a_lvl(a_lvl), .b1_lvl(b1_lvl), .b2_lvl(b2_lvl)
);

// File: tb/reg_bus_exchanger_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module reg_bus_exchanger_tb_top;
    localparam int W = 12;

    typedef struct packed {
        logic [W-1:0] a, b1i, b2i;
        logic         l1, l2, sel, oa, o1, o2;
        logic [W-1:0] ea, e1, e2;
        logic         da, d1, d2;
        logic [W-1:0] la, l1v, l2v;
    } vec_t;

    // Expected values follow R2..R8, starting from the reset state.
    localparam vec_t TBL [5] = '{
        '{12'h111, 12'hAAA, 12'h555, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
          12'hAAA, 12'h111, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000},
        '{12'h222, 12'hAAA, 12'h555, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
          12'h555, 12'h111, 12'h222, 1'b1, 1'b1, 1'b1, 12'h555, 12'h111, 12'h222},
        '{12'h333, 12'h0F0, 12'hF0F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
          12'h0F0, 12'h111, 12'h222, 1'b1, 1'b1, 1'b1, 12'h0F0, 12'h111, 12'h222},
        '{12'h444, 12'h123, 12'h456, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
          12'h456, 12'h444, 12'h444, 1'b0, 1'b1, 1'b0, 12'h0F0, 12'h444, 12'h222},
        '{12'hFFF, 12'hABC, 12'hDEF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
          12'hABC, 12'h444, 12'h444, 1'b0, 1'b0, 1'b0, 12'h0F0, 12'h444, 12'h222}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic ld1_n = 1'b1, ld2_n = 1'b1, pick_1b = 1'b0;
    logic a_oe_n = 1'b1, b1_oe_n = 1'b1, b2_oe_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out, a_lvl, b1_lvl, b2_lvl;
    logic a_drive, b1_drive, b2_drive;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    reg_bus_exchanger #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld1_n(ld1_n), .ld2_n(ld2_n), .pick_1b(pick_1b), .a_oe_n(a_oe_n),
        .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n), .a_out(a_out), .a_drive(a_drive),
        .b1_out(b1_out), .b1_drive(b1_drive), .b2_out(b2_out), .b2_drive(b2_drive),
        .a_lvl(a_lvl), .b1_lvl(b1_lvl), .b2_lvl(b2_lvl)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_in(input vec_t v);
        a_in = v.a; b1_in = v.b1i; b2_in = v.b2i;
        ld1_n = v.l1; ld2_n = v.l2; pick_1b = v.sel;
        a_oe_n = v.oa; b1_oe_n = v.o1; b2_oe_n = v.o2;
    endtask

    task automatic all_zero(input string tag);
        chk({tag, " a_out"}, a_out, '0);
        chk({tag, " b1_out"}, b1_out, '0);
        chk({tag, " b2_out"}, b2_out, '0);
        chk({tag, " drives"}, {9'd0, a_drive, b1_drive, b2_drive}, '0);
        chk({tag, " levels"}, a_lvl | b1_lvl | b2_lvl, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with busy inputs.
        @(negedge clk);
        a_in = 12'h5A5; ld1_n = 1'b0; ld2_n = 1'b0; a_oe_n = 1'b0; b1_oe_n = 1'b0; b2_oe_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        all_zero("R1 initial reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R8.
        for (int i = 0; i < 5; i++) begin
            set_in(TBL[i]);
            @(posedge clk); #1;
            chk("R5 a_out", a_out, TBL[i].ea);
            chk("R2/R7 b1_out", b1_out, TBL[i].e1);
            chk("R3/R7 b2_out", b2_out, TBL[i].e2);
            chk("R6 drives", {9'd0, a_drive, b1_drive, b2_drive},
                {9'd0, TBL[i].da, TBL[i].d1, TBL[i].d2});
            chk("R8 a_lvl", a_lvl, TBL[i].la);
            chk("R8 b1_lvl", b1_lvl, TBL[i].l1v);
            chk("R8 b2_lvl", b2_lvl, TBL[i].l2v);
            if (i == 1) chk("R4 24-bit pair", {b2_out, b1_out} >> 12, 12'h222);
            if (i == 1) chk("R4 low word", {b2_out, b1_out} & 24'h000FFF, 12'h111);
            @(negedge clk);
        end

        // R6: enable change does not reach the flag before the edge.
        a_oe_n = 1'b0; b1_oe_n = 1'b0; b2_oe_n = 1'b0;
        ld1_n = 1'b1; ld2_n = 1'b1; pick_1b = 1'b0; b2_in = 12'h777; a_in = 12'h999;
        #2;
        chk("R6 pre-edge drives", {9'd0, a_drive, b1_drive, b2_drive}, '0);
        @(posedge clk); #1;
        chk("R6 post-edge drives", {9'd0, a_drive, b1_drive, b2_drive}, 12'h007);
        chk("R5 pick high half", a_out, 12'h777);
        chk("R2 hold b1", b1_out, 12'h444);
        chk("R3 hold b2", b2_out, 12'h444);

        // R8: driver off, return register keeps loading, line keeps 777.
        @(negedge clk);
        a_oe_n = 1'b1; pick_1b = 1'b1; b1_in = 12'h999;
        @(posedge clk); #1;
        chk("R7 a_out loads while off", a_out, 12'h999);
        chk("R8 a_lvl kept", a_lvl, 12'h777);
        @(negedge clk);
        b1_in = 12'h888;
        @(posedge clk); #1;
        chk("R5 a_out follows b1", a_out, 12'h888);
        chk("R8 a_lvl still kept", a_lvl, 12'h777);

        // R1: reset mid-run with strobes and enables active.
        @(negedge clk);
        rst_n = 1'b0; ld1_n = 1'b0; ld2_n = 1'b0; a_oe_n = 1'b0; a_in = 12'h3C3;
        @(posedge clk); #1;
        all_zero("R1 mid-run reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule